// File: doc/BRIEF.md
# Packet Receive Ring Buffer Manager

This block places received packet bytes into a byte-wide ring region of a single-port RAM that several packets share. Software sets the lowest and highest addresses of the region while reception is off. Both of those addresses belong to the region. Bytes arrive on a valid/data/last stream, and the final byte of each packet also carries a good/bad flag. The block owns a private write pointer that runs ahead of the data software can see. When a packet ends good and no byte of it was lost, the block publishes that pointer as the committed write position. Otherwise it rewinds the private pointer to the committed position, so the partial packet is forgotten.

Software owns a read-barrier pointer that marks the oldest byte it has not yet consumed. The writer stops just short of that address. Bytes that arrive while the ring is full are thrown away, and stored data is never overwritten. The block reports the free space between the committed position and the barrier, and it counts the packets it discarded. To start, software programs the region, sets the barrier to the region's end, and raises the receive enable.

Top module: `rxring_mgr`

## Requirements
- R1: After reset, region_start is 0, region_end and rd_barrier are all ones, commit_ptr is 0, drop_count is 0 and ram_we is low.
- R2: Accepted bytes are written one per clock at consecutive ascending addresses. The byte after the one written at region_end goes to region_start, and every write address lies between the two bounds inclusive.
- R3: A write to region_start or region_end (cfg_start_we / cfg_end_we with cfg_wdata) takes effect on the next clock only while rx_enable is low. While rx_enable is high such writes are ignored and the readback ports keep their values.
- R4: commit_ptr changes only at the last byte of a packet that has in_good=1 and lost no byte. It then takes the address that follows that last byte. During a packet it keeps its old value.
- R5: The writer never writes at the rd_barrier address. A byte that arrives when the private pointer equals the barrier value held before that clock is discarded without a RAM write, and every later byte of the same packet is discarded too.
- R6: A packet that ends with in_good=0 or that lost any byte is not committed. The next packet starts writing at commit_ptr, and drop_count rises by exactly one for each such packet.
- R7: free_bytes equals (rd_barrier - commit_ptr) modulo the region size (region_end - region_start + 1). It is 0 when the two pointers are equal.
- R8: On the first clock with rx_enable high after it was low, both the private and the committed pointer load region_start, and a byte offered in that clock is ignored. While rx_enable is low no byte is written.
- R9: rd_barrier accepts a write (rd_barrier_we with rd_barrier_wdata) on any clock, whether or not reception is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Receive enable; also locks the region bounds |
| cfg_start_we | input | 1 | Write strobe for the region's lowest address |
| cfg_end_we | input | 1 | Write strobe for the region's highest address |
| cfg_wdata | input | AW | Value for a region bound write |
| rd_barrier_we | input | 1 | Write strobe for the read barrier |
| rd_barrier_wdata | input | AW | New read barrier value |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte is the last of its packet |
| in_good | input | 1 | Packet good, sampled with in_last |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| region_start | output | AW | Current lowest region address |
| region_end | output | AW | Current highest region address |
| rd_barrier | output | AW | Current read barrier |
| commit_ptr | output | AW | Committed write position |
| free_bytes | output | AW+1 | Free bytes between commit_ptr and rd_barrier |
| drop_count | output | CW | Number of discarded packets, wrapping |

## Verification
Two events can fall in the same clock: software moves the read barrier forward, and the packet's last byte arrives just as the private pointer reaches the old barrier. The bench drives rd_barrier_we in exactly the cycle of that final byte. By R5 the full test uses the barrier value from before the edge, so the scoreboard expects no RAM write for that byte. The bench then checks that the packet was rolled back and counted, and that free_bytes already reflects the new barrier.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

  localparam int unsigned PW = 32;

  // Next address in the ring [lo, hi], wrapping at hi.
  function automatic logic [PW-1:0] ring_next(input logic [PW-1:0] p,
                                              input logic [PW-1:0] lo,
                                              input logic [PW-1:0] hi);
    return (p == hi) ? lo : p + 1;
  endfunction

  // Forward distance from 'from' to 'to' inside the ring [lo, hi].
  function automatic logic [PW-1:0] ring_dist(input logic [PW-1:0] from,
                                              input logic [PW-1:0] to,
                                              input logic [PW-1:0] lo,
                                              input logic [PW-1:0] hi);
    logic [PW-1:0] size;
    size = hi - lo + 1;
    return (to >= from) ? to - from : to + size - from;
  endfunction

endpackage

// File: rtl/rxring_cfg.sv
module rxring_cfg #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_enable,
  input  logic          cfg_start_we,
  input  logic          cfg_end_we,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          rd_barrier_we,
  input  logic [AW-1:0] rd_barrier_wdata,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] end_q,
  output logic [AW-1:0] barrier_q
);

  // Bounds are locked while receive runs.
  logic bound_open;
  assign bound_open = !rx_enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= '0;
      end_q     <= '1;
      barrier_q <= '1;
    end else begin
      if (bound_open && cfg_start_we) start_q <= cfg_wdata;
      if (bound_open && cfg_end_we)   end_q   <= cfg_wdata;
      if (rd_barrier_we)              barrier_q <= rd_barrier_wdata;
    end
  end

  assert_start_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable |=> $stable(start_q));
  assert_end_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable |=> $stable(end_q));
  assert_barrier_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_barrier_we |=> (barrier_q == $past(rd_barrier_wdata)));

endmodule

// File: rtl/rxring_wrctl.sv
module rxring_wrctl
  import rxring_pkg::*;
#(
  parameter int AW = 13,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_enable,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic          in_good,
  input  logic [AW-1:0] start_q,
  input  logic [AW-1:0] end_q,
  input  logic [AW-1:0] barrier_q,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [AW-1:0] commit_q,
  output logic [CW-1:0] drop_cnt_q
);

  logic          en_q;
  logic          lost_q;
  logic [AW-1:0] wptr_q;
  logic [AW-1:0] wptr_nx;

  // Named events for the assertions.
  logic load_ev, accept_ev, full_ev, lose_now, commit_ev, drop_ev;

  assign load_ev   = rx_enable && !en_q;
  assign accept_ev = rx_enable && en_q && in_valid;
  assign full_ev   = (wptr_q == barrier_q);
  assign lose_now  = lost_q || full_ev;
  assign commit_ev = accept_ev && in_last && in_good && !lose_now;
  assign drop_ev   = accept_ev && in_last && !commit_ev;

  assign ram_we   = accept_ev && !lose_now;
  assign ram_addr = wptr_q;
  assign wptr_nx  = AW'(ring_next(PW'(wptr_q), PW'(start_q), PW'(end_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      lost_q     <= 1'b0;
      wptr_q     <= '0;
      commit_q   <= '0;
      drop_cnt_q <= '0;
    end else begin
      en_q <= rx_enable;
      if (load_ev) begin
        wptr_q   <= start_q;
        commit_q <= start_q;
        lost_q   <= 1'b0;
      end else if (accept_ev) begin
        if (in_last) begin
          lost_q <= 1'b0;
          if (commit_ev) begin
            wptr_q   <= wptr_nx;
            commit_q <= wptr_nx;
          end else begin
            wptr_q     <= commit_q;
            drop_cnt_q <= drop_cnt_q + 1'b1;
          end
        end else if (lose_now) begin
          lost_q <= 1'b1;
        end else begin
          wptr_q <= wptr_nx;
        end
      end
    end
  end

  assert_in_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && start_q <= end_q) |-> (ram_addr >= start_q && ram_addr <= end_q));
  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !in_last && wptr_q == end_q) |=> (wptr_q == $past(start_q)));
  assert_barrier_safe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr != barrier_q));
  assert_commit_only_on_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_ev || load_ev) |=> $stable(commit_q));
  assert_drop_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> (drop_cnt_q == $past(drop_cnt_q) + 1'b1));
  assert_rollback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> (wptr_q == commit_q));
  assert_enable_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (wptr_q == $past(start_q) && commit_q == $past(start_q)));

endmodule

// File: rtl/rxring_space.sv
module rxring_space
  import rxring_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic [AW-1:0] start_q,
  input  logic [AW-1:0] end_q,
  input  logic [AW-1:0] commit_q,
  input  logic [AW-1:0] barrier_q,
  output logic [AW:0]   free_bytes
);

  assign free_bytes = (AW+1)'(ring_dist(PW'(commit_q), PW'(barrier_q),
                                        PW'(start_q), PW'(end_q)));

  always_comb begin
    if (commit_q == barrier_q)
      assert_full_zero_R7: assert (free_bytes == '0);
  end

endmodule

// File: rtl/rxring_mgr.sv
module rxring_mgr #(
  parameter int AW = 13,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_enable,
  input  logic          cfg_start_we,
  input  logic          cfg_end_we,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          rd_barrier_we,
  input  logic [AW-1:0] rd_barrier_wdata,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          in_good,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output logic [AW-1:0] region_start,
  output logic [AW-1:0] region_end,
  output logic [AW-1:0] rd_barrier,
  output logic [AW-1:0] commit_ptr,
  output logic [AW:0]   free_bytes,
  output logic [CW-1:0] drop_count
);

  logic [AW-1:0] start_q, end_q, barrier_q, commit_q;

  rxring_cfg #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
    .cfg_start_we(cfg_start_we), .cfg_end_we(cfg_end_we), .cfg_wdata(cfg_wdata),
    .rd_barrier_we(rd_barrier_we), .rd_barrier_wdata(rd_barrier_wdata),
    .start_q(start_q), .end_q(end_q), .barrier_q(barrier_q)
  );

  rxring_wrctl #(.AW(AW), .CW(CW)) u_wrctl (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
    .in_valid(in_valid), .in_last(in_last), .in_good(in_good),
    .start_q(start_q), .end_q(end_q), .barrier_q(barrier_q),
    .ram_we(ram_we), .ram_addr(ram_addr),
    .commit_q(commit_q), .drop_cnt_q(drop_count)
  );

  rxring_space #(.AW(AW)) u_space (
    .start_q(start_q), .end_q(end_q), .commit_q(commit_q),
    .barrier_q(barrier_q), .free_bytes(free_bytes)
  );

  assign ram_wdata    = in_data;
  assign region_start = start_q;
  assign region_end   = end_q;
  assign rd_barrier   = barrier_q;
  assign commit_ptr   = commit_q;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> !ram_we);

endmodule

// File: tb/rxring_mgr_tb.sv
module rxring_mgr_tb;

  localparam int AW = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_enable = 1'b0;
  logic          cfg_start_we = 1'b0, cfg_end_we = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          rd_barrier_we = 1'b0;
  logic [AW-1:0] rd_barrier_wdata = '0;
  logic          in_valid = 1'b0, in_last = 1'b0, in_good = 1'b0;
  logic [7:0]    in_data = '0;
  logic          ram_we;
  logic [AW-1:0] ram_addr, region_start, region_end, rd_barrier, commit_ptr;
  logic [7:0]    ram_wdata;
  logic [AW:0]   free_bytes;
  logic [CW-1:0] drop_count;

  always #4 clk = ~clk;

  rxring_mgr #(.AW(AW), .CW(CW)) u_dut (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { int a; int d; } exp_t;
  exp_t sb[$];

  // Reference model state
  int m_lo = 0, m_hi = 255, m_bar = 255, m_w = 0, m_c = 0, m_cnt = 0;
  bit m_en = 0, m_lost = 0;

  function automatic int nxt(int p);
    return (p == m_hi) ? m_lo : p + 1;
  endfunction

  function automatic int space_left();
    int sz;
    sz = m_hi - m_lo + 1;
    return (m_bar >= m_c) ? m_bar - m_c : m_bar + sz - m_c;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every RAM write.
  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R5 actual=write@%0d expected=no write", ram_addr);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (int'(ram_addr) != e.a || int'(ram_wdata) != e.d) begin
          fails++;
          $display("FAIL R2 actual=%0d/%0d expected=%0d/%0d",
                   ram_addr, ram_wdata, e.a, e.d);
        end
      end
    end
  end

  // Driver: one stream byte, with the model advanced alongside it.
  task automatic send_byte(int d, bit last, bit good);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = 8'(d); in_last = last; in_good = good;
    if (m_en) begin
      if (!m_lost && m_w != m_bar) begin
        sb.push_back('{a: m_w, d: d & 255});
        m_w = nxt(m_w);
      end else m_lost = 1;
      if (last) begin
        if (good && !m_lost) m_c = m_w;
        else begin m_w = m_c; m_cnt++; end
        m_lost = 0;
      end
    end
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; rd_barrier_we = 1'b0;
    cfg_start_we = 1'b0; cfg_end_we = 1'b0;
  endtask

  task automatic send_pkt(int n, int base, bit good);
    for (int i = 0; i < n; i++) send_byte(base + i, i == n - 1, good);
    idle();
  endtask

  task automatic set_barrier(int v);
    @(posedge clk); #1; rd_barrier_we = 1'b1; rd_barrier_wdata = AW'(v); m_bar = v;
    idle();
  endtask

  task automatic enable_rx();
    @(posedge clk); #1; rx_enable = 1'b1;
    m_en = 1; m_w = m_lo; m_c = m_lo; m_lost = 0;
    idle();
  endtask

  task automatic check_state(string req);
    @(negedge clk);
    chk({req, " commit"}, int'(commit_ptr), m_c);
    chk({req, " free"},   int'(free_bytes), space_left());
    chk({req, " drops"},  int'(drop_count), m_cnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 start", int'(region_start), 0);
    chk("R1 end", int'(region_end), 255);
    chk("R1 barrier", int'(rd_barrier), 255);
    chk("R1 commit", int'(commit_ptr), 0);
    chk("R1 drops", int'(drop_count), 0);
    chk("R1 we", int'(ram_we), 0);

    // R3: bounds accepted while disabled; R9 barrier write
    @(posedge clk); #1; cfg_start_we = 1; cfg_wdata = 16; idle();
    @(posedge clk); #1; cfg_end_we = 1; cfg_wdata = 31; idle();
    m_lo = 16; m_hi = 31;
    set_barrier(31);
    @(negedge clk);
    chk("R3 start open", int'(region_start), 16);
    chk("R3 end open", int'(region_end), 31);
    chk("R9 barrier", int'(rd_barrier), 31);

    // R8: enable loads pointers; byte in the enable cycle ignored
    @(posedge clk); #1; rx_enable = 1'b1; in_valid = 1; in_data = 8'hEE; in_last = 1; in_good = 1;
    m_en = 1; m_w = m_lo; m_c = m_lo;
    idle();
    check_state("R8");
    chk("R7 initial free", int'(free_bytes), 15);

    // R3: bounds locked while enabled
    @(posedge clk); #1; cfg_start_we = 1; cfg_end_we = 1; cfg_wdata = 40; idle();
    @(negedge clk);
    chk("R3 start locked", int'(region_start), 16);
    chk("R3 end locked", int'(region_end), 31);

    // R4: commit holds mid-packet, moves at good end
    send_byte(8'h10, 0, 1); send_byte(8'h11, 0, 1); send_byte(8'h12, 0, 1);
    @(negedge clk);
    chk("R4 mid packet commit", int'(commit_ptr), 16);
    send_byte(8'h13, 0, 1); send_byte(8'h14, 1, 1); idle();
    check_state("R4");
    chk("R4 commit value", int'(commit_ptr), 21);

    // R6: bad packet rolls back
    send_pkt(3, 8'h20, 0);
    check_state("R6 bad");
    send_pkt(4, 8'h30, 1);
    check_state("R6 after rollback");

    // R2 / R7: wrap and wrapped free space
    set_barrier(22);
    check_state("R7 wrapped");
    send_pkt(9, 8'h40, 1);
    check_state("R2 wrap");
    chk("R2 commit after wrap", int'(commit_ptr), 18);

    // R5: overflow drops tail, packet discarded
    send_pkt(6, 8'h50, 1);
    check_state("R5 overflow");

    // Same cycle: barrier advance with the last byte hitting the old barrier
    send_byte(8'h60, 0, 1); send_byte(8'h61, 0, 1);
    send_byte(8'h62, 0, 1); send_byte(8'h63, 0, 1);
    send_byte(8'h64, 1, 1);
    rd_barrier_we = 1'b1; rd_barrier_wdata = 8'd30;
    idle();
    m_bar = 30;
    check_state("R5 same cycle");
    send_pkt(3, 8'h70, 1);
    check_state("R5 after barrier advance");

    // R8: disabled receive writes nothing
    @(posedge clk); #1; rx_enable = 1'b0; m_en = 0;
    send_pkt(3, 8'h80, 1);
    check_state("R8 disabled");

    // R8: re-enable reloads to a new start
    @(posedge clk); #1; cfg_start_we = 1; cfg_end_we = 1; cfg_wdata = 100; idle();
    @(posedge clk); #1; cfg_end_we = 1; cfg_wdata = 107; idle();
    m_lo = 100; m_hi = 107;
    set_barrier(107);
    enable_rx();
    check_state("R8 reload");
    send_pkt(2, 8'h90, 1);
    check_state("R8 packet after reload");

    repeat (2) @(negedge clk);
    chk("R2 scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule